// File: doc/BRIEF.md
# Parallel Camera Capture Receiver

This block takes pixels from an 8-bit or 16-bit parallel camera bus and turns them into a stream of bytes. It runs on a core clock and oversamples the pixel clock, frame sync, line sync and data-enable pins. Each active pixel clock transition is one capture point. On a capture point where data-enable is active, the sample is optionally bit-reversed and byte-swapped. It then leaves the block as one byte, or as two bytes on consecutive core cycles.

Two event counters run alongside the byte stream. The first counts the bytes captured in the current frame. It raises a one-cycle end-of-transfer pulse when the count reaches the programmed length plus one. The second counts line-sync rising edges. It raises a line pulse when that count reaches the programmed line target plus one. Both counters restart at every filtered frame-sync rise. The frame sync passes through a glitch filter that can be bypassed and has a programmable hold threshold.

All settings arrive on staged configuration inputs. They take effect only when an update strobe copies them into the active set.

Top module: `cam_capture_rx`

## Requirements
- R1: With `cfg_wide`=0, each accepted sample yields one byte equal to `pix_data[7:0]`, and `pix_data[15:8]` is ignored. With `cfg_wide`=1, each accepted sample yields two bytes on consecutive cycles, low byte first. The first byte appears on `out_valid`/`out_byte` in the cycle after the capture edge.
- R2: With `cfg_bit_rev`=1, bit i of the sample moves to bit 7-i in 8-bit mode, or to bit 15-i in 16-bit mode. This happens before any byte swap.
- R3: With `cfg_byte_swap`=1 in 16-bit mode, the high byte is sent first. In 8-bit mode this setting has no effect.
- R4: The byte count is incremented by 1 or 2 per accepted sample. `eot_pulse` is high for one cycle, together with the first byte of the sample that moves the count from below `cfg_byte_len`+1 to at or above it. It fires at most once per frame.
- R5: A line event is a rising `pix_hsync` between consecutive capture edges. `line_pulse` is high for one cycle when the line count reaches `cfg_line_tgt`+1. It fires only while `cfg_line_en`=1.
- R6: With `cfg_pclk_inv`=0, capture happens on rising `pix_clk` transitions. With `cfg_pclk_inv`=1, capture happens on falling transitions only.
- R7: Data-enable is active when `pix_de` XOR `cfg_de_inv` is 1. Samples without it produce no byte and are not counted.
- R8: With the filter bypassed, `vsync_filt` follows `pix_vsync` on each capture edge. With the filter enabled, `vsync_filt` takes a new level only after `pix_vsync` has held that level on `cfg_vs_thr`+1 consecutive capture edges.
- R9: Staged configuration has no effect until the clock on which `cfg_update` is high. It is applied from the next cycle.
- R10: Both counts restart from zero on the capture edge where `vsync_filt` rises. A byte taken on that same edge counts as the first of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled by clk |
| pix_vsync | input | 1 | Frame sync |
| pix_hsync | input | 1 | Line sync |
| pix_de | input | 1 | Data enable |
| pix_data | input | 16 | Pixel data bus |
| cfg_wide | input | 1 | Staged: 1 = 16-bit samples |
| cfg_bit_rev | input | 1 | Staged: reverse bit order |
| cfg_byte_swap | input | 1 | Staged: swap the two bytes of a 16-bit sample |
| cfg_de_inv | input | 1 | Staged: data enable active low |
| cfg_pclk_inv | input | 1 | Staged: capture on falling pixel clock |
| cfg_vs_filt_en | input | 1 | Staged: enable frame-sync filter |
| cfg_vs_thr | input | 3 | Staged: filter threshold |
| cfg_byte_len | input | 16 | Staged: end-of-transfer byte count minus one |
| cfg_line_tgt | input | 6 | Staged: line pulse count minus one |
| cfg_line_en | input | 1 | Staged: enable line pulse |
| cfg_update | input | 1 | Copy staged settings to active |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Output byte |
| eot_pulse | output | 1 | End-of-transfer pulse |
| line_pulse | output | 1 | Line-count pulse |
| vsync_filt | output | 1 | Filtered frame sync level |

## Verification
The bench builds the block with its default widths: a 16-bit byte length, a 6-bit line target and a 3-bit filter threshold. It programs small lengths and targets, so both pulses and the 16-bit count step past the target are reached within a few pixels. At threshold 2 it checks a two-edge glitch that must be rejected and a three-edge hold that must pass. At threshold 0 it checks immediate passage.

// File: rtl/cam_rx_pkg.sv
package cam_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 2 * BYTE_W;
  localparam int BLEN_W = 16;
  localparam int LINE_W = 6;
  localparam int THR_W  = 3;

  typedef struct packed {
    logic              wide;
    logic              bit_rev;
    logic              byte_swap;
    logic              de_inv;
    logic              pclk_inv;
    logic              vs_filt_en;
    logic [THR_W-1:0]  vs_thr;
    logic [BLEN_W-1:0] byte_len;
    logic [LINE_W-1:0] line_tgt;
    logic              line_en;
  } cam_cfg_t;
endpackage

// File: rtl/cam_cfg_shadow.sv
module cam_cfg_shadow
  import cam_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     update,
  input  cam_cfg_t staged,
  output cam_cfg_t active
);
  cam_cfg_t active_n;

  always_comb begin
    active_n = active;
    if (update) active_n = staged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= '0;
    else        active <= active_n;
  end
endmodule

// File: rtl/cam_vs_filter.sv
module cam_vs_filter #(
  parameter int THR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_edge,
  input  logic             vs_in,
  input  logic             filt_en,
  input  logic [THR_W-1:0] thr,
  output logic             level,
  output logic             rise
);
  logic             level_n;
  logic [THR_W-1:0] run, run_n;

  always_comb begin
    level_n = level;
    run_n   = run;
    if (pix_edge) begin
      if (!filt_en) begin
        level_n = vs_in;
        run_n   = '0;
      end else if (vs_in == level) begin
        run_n = '0;
      end else if (run == thr) begin
        level_n = vs_in;
        run_n   = '0;
      end else begin
        run_n = run + 1'b1;
      end
    end
  end

  assign rise = level_n & ~level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      run   <= '0;
    end else if (pix_edge) begin
      level <= level_n;
      run   <= run_n;
    end
  end
endmodule

// File: rtl/cam_byte_packer.sv
module cam_byte_packer #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [2*BYTE_W-1:0] data,
  input  logic                wide,
  input  logic                bit_rev,
  input  logic                byte_swap,
  output logic                out_valid,
  output logic [BYTE_W-1:0]   out_byte
);
  localparam int DW = 2 * BYTE_W;

  logic [DW-1:0]     rev_w, ord;
  logic [BYTE_W-1:0] rev_b, first_b, second_b;
  logic [BYTE_W-1:0] hold, hold_n, out_byte_n;
  logic              pend, pend_n, out_valid_n;

  for (genvar i = 0; i < DW; i++) begin : g_rev_w
    assign rev_w[i] = data[DW-1-i];
  end
  for (genvar j = 0; j < BYTE_W; j++) begin : g_rev_b
    assign rev_b[j] = data[BYTE_W-1-j];
  end

  always_comb begin
    if (wide) ord = bit_rev ? rev_w : data;
    else      ord = {{BYTE_W{1'b0}}, (bit_rev ? rev_b : data[BYTE_W-1:0])};
    if (wide && byte_swap) begin
      first_b  = ord[DW-1:BYTE_W];
      second_b = ord[BYTE_W-1:0];
    end else begin
      first_b  = ord[BYTE_W-1:0];
      second_b = ord[DW-1:BYTE_W];
    end
  end

  always_comb begin
    out_valid_n = 1'b0;
    out_byte_n  = out_byte;
    pend_n      = pend;
    hold_n      = hold;
    if (accept) begin
      out_valid_n = 1'b1;
      out_byte_n  = first_b;
      pend_n      = wide;
      hold_n      = second_b;
    end else if (pend) begin
      out_valid_n = 1'b1;
      out_byte_n  = hold;
      pend_n      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      pend      <= 1'b0;
      hold      <= '0;
    end else begin
      out_valid <= out_valid_n;
      out_byte  <= out_byte_n;
      pend      <= pend_n;
      hold      <= hold_n;
    end
  end
endmodule

// File: rtl/cam_rx_counters.sv
module cam_rx_counters #(
  parameter int BLEN_W = 16,
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_edge,
  input  logic              accept,
  input  logic              wide,
  input  logic              line_evt,
  input  logic              frame_rise,
  input  logic [BLEN_W-1:0] byte_len,
  input  logic [LINE_W-1:0] line_tgt,
  input  logic              line_en,
  output logic              eot_pulse,
  output logic              line_pulse
);
  localparam int BC_W = BLEN_W + 1;
  localparam int LC_W = LINE_W + 1;

  logic [BC_W-1:0] bcnt, bcnt_n, bbase, btgt;
  logic [BC_W:0]   bsum;
  logic [1:0]      binc;
  logic [LC_W-1:0] lcnt, lcnt_n, lbase, ltgt;
  logic [LC_W:0]   lsum;
  logic            eot_n, line_n;

  always_comb begin
    bbase  = frame_rise ? '0 : bcnt;
    binc   = accept ? (wide ? 2'd2 : 2'd1) : 2'd0;
    bsum   = {1'b0, bbase} + {{(BC_W-1){1'b0}}, binc};
    btgt   = {1'b0, byte_len} + {{(BC_W-1){1'b0}}, 1'b1};
    bcnt_n = bsum[BC_W] ? '1 : bsum[BC_W-1:0];
    eot_n  = accept && (bbase < btgt) && (bsum >= {1'b0, btgt});

    lbase  = frame_rise ? '0 : lcnt;
    lsum   = {1'b0, lbase} + {{LC_W{1'b0}}, line_evt};
    ltgt   = {1'b0, line_tgt} + {{(LC_W-1){1'b0}}, 1'b1};
    lcnt_n = lsum[LC_W] ? '1 : lsum[LC_W-1:0];
    line_n = line_en && line_evt && (lbase < ltgt) && (lsum >= {1'b0, ltgt});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt       <= '0;
      lcnt       <= '0;
      eot_pulse  <= 1'b0;
      line_pulse <= 1'b0;
    end else begin
      if (pix_edge) begin
        bcnt <= bcnt_n;
        lcnt <= lcnt_n;
      end
      eot_pulse  <= eot_n;
      line_pulse <= line_n;
    end
  end
endmodule

// File: rtl/cam_capture_rx.sv
module cam_capture_rx
  import cam_rx_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int DW = DATA_W,
  parameter int LW = BLEN_W,
  parameter int NW = LINE_W,
  parameter int TW = THR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_clk,
  input  logic          pix_vsync,
  input  logic          pix_hsync,
  input  logic          pix_de,
  input  logic [DW-1:0] pix_data,
  input  logic          cfg_wide,
  input  logic          cfg_bit_rev,
  input  logic          cfg_byte_swap,
  input  logic          cfg_de_inv,
  input  logic          cfg_pclk_inv,
  input  logic          cfg_vs_filt_en,
  input  logic [TW-1:0] cfg_vs_thr,
  input  logic [LW-1:0] cfg_byte_len,
  input  logic [NW-1:0] cfg_line_tgt,
  input  logic          cfg_line_en,
  input  logic          cfg_update,
  output logic          out_valid,
  output logic [BW-1:0] out_byte,
  output logic          eot_pulse,
  output logic          line_pulse,
  output logic          vsync_filt
);
  cam_cfg_t staged_cfg, act_cfg;
  logic     pclk_q, hs_q, hs_q_n;
  logic     pix_edge, accept, line_evt, frame_rise;

  always_comb begin
    staged_cfg.wide       = cfg_wide;
    staged_cfg.bit_rev    = cfg_bit_rev;
    staged_cfg.byte_swap  = cfg_byte_swap;
    staged_cfg.de_inv     = cfg_de_inv;
    staged_cfg.pclk_inv   = cfg_pclk_inv;
    staged_cfg.vs_filt_en = cfg_vs_filt_en;
    staged_cfg.vs_thr     = cfg_vs_thr;
    staged_cfg.byte_len   = cfg_byte_len;
    staged_cfg.line_tgt   = cfg_line_tgt;
    staged_cfg.line_en    = cfg_line_en;
  end

  cam_cfg_shadow u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .update (cfg_update),
    .staged (staged_cfg),
    .active (act_cfg)
  );

  always_comb begin
    pix_edge = act_cfg.pclk_inv ? (pclk_q & ~pix_clk) : (~pclk_q & pix_clk);
    accept   = pix_edge & (pix_de ^ act_cfg.de_inv);
    line_evt = pix_edge & pix_hsync & ~hs_q;
    hs_q_n   = pix_edge ? pix_hsync : hs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q <= 1'b0;
      hs_q   <= 1'b0;
    end else begin
      pclk_q <= pix_clk;
      hs_q   <= hs_q_n;
    end
  end

  cam_vs_filter #(.THR_W(TW)) u_vsf (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_edge (pix_edge),
    .vs_in    (pix_vsync),
    .filt_en  (act_cfg.vs_filt_en),
    .thr      (act_cfg.vs_thr),
    .level    (vsync_filt),
    .rise     (frame_rise)
  );

  cam_byte_packer #(.BYTE_W(BW)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .data      (pix_data),
    .wide      (act_cfg.wide),
    .bit_rev   (act_cfg.bit_rev),
    .byte_swap (act_cfg.byte_swap),
    .out_valid (out_valid),
    .out_byte  (out_byte)
  );

  cam_rx_counters #(.BLEN_W(LW), .LINE_W(NW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_edge   (pix_edge),
    .accept     (accept),
    .wide       (act_cfg.wide),
    .line_evt   (line_evt),
    .frame_rise (frame_rise),
    .byte_len   (act_cfg.byte_len),
    .line_tgt   (act_cfg.line_tgt),
    .line_en    (act_cfg.line_en),
    .eot_pulse  (eot_pulse),
    .line_pulse (line_pulse)
  );
endmodule

// File: rtl/cam_capture_rx_chk.sv
module cam_capture_rx_chk
  import cam_rx_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     eot_pulse,
  input logic     out_valid,
  input logic     line_pulse,
  input logic     line_en,
  input logic     cfg_update,
  input cam_cfg_t act,
  input logic     pix_edge,
  input logic     vsync_filt
);
  AST_EOT_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    eot_pulse |-> out_valid); // R4

  AST_LINE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse |-> $past(line_en)); // R5

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_update |=> $stable(act)); // R9

  AST_VS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_edge |=> $stable(vsync_filt)); // R8
endmodule

bind cam_capture_rx cam_capture_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .eot_pulse  (eot_pulse),
  .out_valid  (out_valid),
  .line_pulse (line_pulse),
  .line_en    (act_cfg.line_en),
  .cfg_update (cfg_update),
  .act        (act_cfg),
  .pix_edge   (pix_edge),
  .vsync_filt (vsync_filt)
);

// File: tb/sim_cam_capture_rx.sv
module sim_cam_capture_rx;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        pix_clk, pix_vsync, pix_hsync, pix_de;
  logic [15:0] pix_data;
  logic        cfg_wide, cfg_bit_rev, cfg_byte_swap, cfg_de_inv, cfg_pclk_inv;
  logic        cfg_vs_filt_en, cfg_line_en, cfg_update;
  logic [2:0]  cfg_vs_thr;
  logic [15:0] cfg_byte_len;
  logic [5:0]  cfg_line_tgt;
  logic        out_valid, eot_pulse, line_pulse, vsync_filt;
  logic [7:0]  out_byte;

  int errors = 0;
  int checks = 0;
  int got    = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  string      cur_tag = "R1";
  string      eot_tag = "R4";

  // model of the active configuration and frame state
  logic m_wide, m_brev, m_swap, m_deinv, m_fen, m_len_en;
  int   m_thr, m_len, m_ltgt;
  logic m_idle, m_lvl, m_hs;
  int   m_run, m_bytes, m_lines;

  cam_capture_rx u0 (
    .clk(clk), .rst_n(rst_n), .pix_clk(pix_clk), .pix_vsync(pix_vsync),
    .pix_hsync(pix_hsync), .pix_de(pix_de), .pix_data(pix_data),
    .cfg_wide(cfg_wide), .cfg_bit_rev(cfg_bit_rev), .cfg_byte_swap(cfg_byte_swap),
    .cfg_de_inv(cfg_de_inv), .cfg_pclk_inv(cfg_pclk_inv),
    .cfg_vs_filt_en(cfg_vs_filt_en), .cfg_vs_thr(cfg_vs_thr),
    .cfg_byte_len(cfg_byte_len), .cfg_line_tgt(cfg_line_tgt),
    .cfg_line_en(cfg_line_en), .cfg_update(cfg_update),
    .out_valid(out_valid), .out_byte(out_byte), .eot_pulse(eot_pulse),
    .line_pulse(line_pulse), .vsync_filt(vsync_filt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rev16(input logic [15:0] x);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = x[15-i];
    return r;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = x[7-i];
    return r;
  endfunction

  // monitor: pops expected bytes as the design emits them
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      got++;
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL %s: actual=%0h expected=none (unexpected byte)", cur_tag, out_byte);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, out_byte, e);
      end
    end
  end

  task automatic upd();
    @(negedge clk);
    cfg_update = 1'b1;
    m_wide = cfg_wide; m_brev = cfg_bit_rev; m_swap = cfg_byte_swap;
    m_deinv = cfg_de_inv; m_fen = cfg_vs_filt_en; m_thr = int'(cfg_vs_thr);
    m_len = int'(cfg_byte_len); m_ltgt = int'(cfg_line_tgt); m_len_en = cfg_line_en;
    @(negedge clk);
    cfg_update = 1'b0;
  endtask

  // driver: one pixel clock period of four core cycles
  task automatic pix(input logic [15:0] d, input logic de, input logic hs, input logic vs);
    logic acc, lvl_n, rise, hse, ee, le;
    logic [15:0] o;
    logic [7:0] b0, b1;
    int bo, lo;
    @(negedge clk);
    pix_data = d; pix_de = de; pix_hsync = hs; pix_vsync = vs; pix_clk = ~m_idle;
    acc = de ^ m_deinv;
    lvl_n = m_lvl;
    if (!m_fen) begin
      lvl_n = vs; m_run = 0;
    end else if (vs == m_lvl) begin
      m_run = 0;
    end else begin
      m_run++;
      if (m_run == m_thr + 1) begin lvl_n = vs; m_run = 0; end
    end
    rise = lvl_n & ~m_lvl;
    m_lvl = lvl_n;
    hse = hs & ~m_hs;
    m_hs = hs;
    if (rise) begin m_bytes = 0; m_lines = 0; end
    bo = m_bytes; lo = m_lines;
    if (acc) begin
      if (m_wide) o = m_brev ? rev16(d) : d;
      else        o = {8'h00, (m_brev ? rev8(d[7:0]) : d[7:0])};
      if (m_wide && m_swap) begin b0 = o[15:8]; b1 = o[7:0]; end
      else                  begin b0 = o[7:0];  b1 = o[15:8]; end
      exp_q.push_back(b0); tag_q.push_back(cur_tag);
      if (m_wide) begin exp_q.push_back(b1); tag_q.push_back(cur_tag); end
      m_bytes += m_wide ? 2 : 1;
    end
    if (hse) m_lines++;
    ee = acc && (bo < m_len + 1) && (m_bytes >= m_len + 1);
    le = m_len_en && hse && (lo < m_ltgt + 1) && (m_lines >= m_ltgt + 1);
    @(negedge clk);
    chk(eot_tag, eot_pulse, ee);
    chk("R5", line_pulse, le);
    chk("R8", vsync_filt, m_lvl);
    @(negedge clk);
    pix_clk = m_idle;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int g0;
    rst_n = 1'b0;
    pix_clk = 0; pix_vsync = 0; pix_hsync = 0; pix_de = 0; pix_data = '0;
    cfg_wide = 0; cfg_bit_rev = 0; cfg_byte_swap = 0; cfg_de_inv = 0; cfg_pclk_inv = 0;
    cfg_vs_filt_en = 0; cfg_vs_thr = '0; cfg_byte_len = '0; cfg_line_tgt = '0;
    cfg_line_en = 0; cfg_update = 0;
    m_wide = 0; m_brev = 0; m_swap = 0; m_deinv = 0; m_fen = 0; m_len_en = 0;
    m_thr = 0; m_len = 0; m_ltgt = 0; m_idle = 0; m_lvl = 0; m_hs = 0;
    m_run = 0; m_bytes = 0; m_lines = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", out_valid, 0);
    chk("R4", eot_pulse, 0);
    chk("R5", line_pulse, 0);
    chk("R8", vsync_filt, 0);

    // R1 / R4 / R5: 8-bit, 5-byte transfer, pulse on second line
    cfg_byte_len = 16'd4; cfg_line_tgt = 6'd1; cfg_line_en = 1;
    upd();
    cur_tag = "R1";
    pix(16'h0000, 0, 0, 1);
    for (int k = 0; k < 7; k++)
      pix(16'hAB00 | 16'(k * 17 + 3), 1, k[0], 1);

    // R2: bit reversal in 8-bit mode
    cfg_bit_rev = 1; upd();
    cur_tag = "R2";
    pix(16'h0001, 1, 0, 1);
    pix(16'h55C3, 1, 0, 1);
    // R3: byte swap has no effect in 8-bit mode
    cfg_byte_swap = 1; upd();
    cur_tag = "R3";
    pix(16'h1234, 1, 0, 1);
    pix(16'hFF0E, 1, 0, 1);

    // R1 / R4: 16-bit, length 5 crossed by a 2-byte step
    cfg_bit_rev = 0; cfg_byte_swap = 0; cfg_wide = 1; upd();
    cur_tag = "R1";
    pix(16'h0000, 0, 0, 0);
    pix(16'h0000, 0, 0, 1);
    pix(16'h1234, 1, 0, 1);
    pix(16'h5678, 1, 0, 1);
    pix(16'h9ABC, 1, 0, 1);
    pix(16'hDEF0, 1, 0, 1);
    cfg_byte_swap = 1; upd();
    cur_tag = "R3";
    pix(16'hA55A, 1, 0, 1);
    pix(16'h0102, 1, 0, 1);
    cfg_bit_rev = 1; cfg_byte_swap = 0; upd();
    cur_tag = "R2";
    pix(16'h8001, 1, 0, 1);
    pix(16'h00F0, 1, 0, 1);

    // R7: data-enable inverted
    cfg_bit_rev = 0; cfg_de_inv = 1; upd();
    cur_tag = "R7";
    repeat (3) @(negedge clk);
    g0 = got;
    pix(16'h1111, 1, 0, 1);
    pix(16'h2222, 1, 0, 1);
    repeat (3) @(negedge clk);
    chk("R7", got, g0);
    pix(16'h3344, 0, 0, 1);
    repeat (3) @(negedge clk);
    chk("R7", got, g0 + 2);
    cfg_de_inv = 0; upd();

    // R5: line pulse disabled
    cfg_line_en = 0; cfg_line_tgt = 6'd0; upd();
    cur_tag = "R5";
    pix(16'h0000, 0, 0, 0);
    pix(16'h0000, 0, 1, 1);
    pix(16'h0000, 0, 0, 1);
    pix(16'h0000, 0, 1, 1);
    cfg_line_en = 1; upd();
    pix(16'h0000, 0, 0, 0);
    pix(16'h0000, 0, 1, 1);

    // R9: staged change without update has no effect
    cfg_wide = 0; cfg_byte_swap = 1;
    cur_tag = "R9";
    pix(16'hC0DE, 1, 0, 1);
    upd();
    pix(16'hC0DE, 1, 0, 1);

    // R6: capture on falling pixel clock
    cfg_pclk_inv = 1; upd();
    cur_tag = "R6";
    @(negedge clk);
    pix_de = 1; pix_data = 16'h00EE; pix_clk = 1; m_idle = 1;
    repeat (3) @(negedge clk);
    pix(16'h0077, 1, 0, 1);
    pix(16'h0088, 1, 0, 1);
    cfg_pclk_inv = 0; upd();
    @(negedge clk);
    pix_clk = 0; m_idle = 0;
    repeat (3) @(negedge clk);
    pix(16'h0099, 1, 0, 1);

    // R8: vsync filter, threshold 2
    cfg_vs_filt_en = 1; cfg_vs_thr = 3'd2; upd();
    cur_tag = "R8";
    pix(16'h0000, 0, 0, 0);
    pix(16'h0000, 0, 0, 0);
    pix(16'h0000, 0, 0, 1);
    pix(16'h0000, 0, 0, 0);
    pix(16'h0000, 0, 0, 0);
    pix(16'h0000, 0, 0, 0);
    pix(16'h0000, 0, 0, 1);
    pix(16'h0000, 0, 0, 1);
    pix(16'h0000, 0, 0, 1);
    cfg_vs_thr = 3'd0; upd();
    pix(16'h0000, 0, 0, 0);
    pix(16'h0000, 0, 0, 1);

    // R10: counts restart on frame start
    cfg_vs_filt_en = 0; cfg_byte_len = 16'd2; upd();
    cur_tag = "R10"; eot_tag = "R10";
    pix(16'h0000, 0, 0, 0);
    pix(16'h0041, 1, 0, 1);
    pix(16'h0042, 1, 0, 1);
    pix(16'h0000, 0, 0, 0);
    pix(16'h0043, 1, 0, 1);
    pix(16'h0044, 1, 0, 1);
    pix(16'h0045, 1, 0, 1);
    pix(16'h0046, 1, 0, 1);

    repeat (6) @(negedge clk);
    chk("R1", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule